// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Spurious Detection

This block collects interrupt requests from a set of active-low external pins and hands a single priority level to a processor core. Every source owns a three-bit priority level and one bit in a mask word. Each pin can be set to level-sensitive capture, where it is pending while held low, or to edge capture, where a falling edge sets a sticky flag that software clears by writing a one to it.

Recognition is a two-stage registered path. It finds the highest level among sources that are pending and unmasked, and drives that level toward the core only when it is strictly above the core's current three-bit priority mask. When the core acknowledges a level, the controller looks at the mask and pending state again, as they stand in the acknowledge cycle. It returns the vector of the lowest-numbered source that still qualifies at that level. If none qualifies, it returns a fixed spurious vector. The window between the two looks is fixed, so software that masks or clears a source inside it sees the spurious outcome every time.

Registers sit on a small synchronous bus. A write takes effect at the clock edge on which `bus_we` is high, and reads are combinational.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every source is masked (mask register reads all ones), every level register reads 0, every pin is in level mode, `irq_level_o` is 0 and `ack_valid_o` is 0.
- R2: The level of source n is read and written in bits [2:0] at address 16+n. A source with level 0 never raises `irq_level_o` and never wins an acknowledge.
- R3: The mask register sits at address 0, with bit n for source n. A 1 masks the source and a 0 enables it. A masked source is ignored by recognition and by acknowledge.
- R4: `irq_level_o` carries the recognized level only when that level is strictly greater than `core_mask_i`. Otherwise it is 0.
- R5: The recognized level is the highest level among pending, unmasked sources. It reaches `irq_level_o` two clock edges after the register edge on which the pending or mask state changed.
- R6: When `iack_i` is high at a clock edge, `ack_valid_o` is high for the following cycle. `ack_vector_o` then holds VEC_BASE+n for the winning source n, which must be pending and unmasked and have a level equal to `iack_level_i` in the acknowledge cycle.
- R7: If no pending, unmasked source has the acknowledged level in the acknowledge cycle, `ack_vector_o` is SPUR_VEC. This covers a mask bit set, or a request cleared, after recognition.
- R8: The mode register sits at address 1, where bit n = 1 selects edge capture for pin n. In edge mode a falling edge of the pin sets a sticky pending flag that stays set after the pin returns high. Writing 1 to bit n at address 2 clears the flag.
- R9: In level mode source n is pending only while its pin is low. Address 2 reads the pending vector, bit n for source n.
- R10: When several qualifying sources share the acknowledged level, the lowest source index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_i | input | NUM_SRC | Active-low external request pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data (combinational) |
| core_mask_i | input | 3 | Core's current priority mask |
| irq_level_o | output | 3 | Level presented to the core, 0 for none |
| iack_i | input | 1 | Acknowledge strobe from the core |
| iack_level_i | input | 3 | Level being acknowledged |
| ack_valid_o | output | 1 | Vector valid, one cycle after acknowledge |
| ack_vector_o | output | 8 | Source vector or spurious vector |

## Verification
The bench builds the controller with NUM_SRC=6, VEC_BASE=64 and SPUR_VEC=24. Six sources are enough for two sources sharing level 5, a level-0 source, one edge-mode pin and a low-priority source used to open the race window, and the source vectors 64..69 stay well apart from the spurious value. The small source count also keeps the pending vector readable in a single bus read. With it the bench can mask a source, and separately clear an edge flag, inside the two-cycle recognition window, then acknowledge and expect the spurious vector.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int LVL_W  = 3;
    localparam int ADDR_W = 5;
    localparam int VEC_W  = 8;

    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [VEC_W-1:0]  vector_t;

    localparam addr_t ADDR_MASK = 5'd0;
    localparam addr_t ADDR_MODE = 5'd1;
    localparam addr_t ADDR_PEND = 5'd2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_MODE,
        SEL_PEND,
        SEL_LEVEL
    } reg_sel_e;

    typedef struct packed {
        logic    valid;
        vector_t vector;
    } ack_rsp_t;

    function automatic reg_sel_e decode_addr(input addr_t a, input int nsrc);
        reg_sel_e s;
        if (a == ADDR_MASK)                          s = SEL_MASK;
        else if (a == ADDR_MODE)                     s = SEL_MODE;
        else if (a == ADDR_PEND)                     s = SEL_PEND;
        else if (a[4] && (int'(a[3:0]) < nsrc))      s = SEL_LEVEL;
        else                                         s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/irq_pin_capture.sv
module irq_pin_capture (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic pending
);
    logic pin_q;
    logic pin_qq;
    logic flag_q;
    logic fall;

    assign fall = pin_qq & ~pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= 1'b1;
            pin_qq <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            pin_q  <= pin_n;
            pin_qq <= pin_q;
            flag_q <= (flag_q & ~clr) | fall;
        end
    end

    assign pending = edge_mode ? flag_q : ~pin_q;

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q) else $error("edge flag lost"); // R8

endmodule

// File: rtl/irq_level_resolve.sv
module irq_level_resolve
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   active,
    input  level_t [NUM_SRC-1:0] levels,
    input  level_t               core_mask,
    output level_t               irq_level
);
    level_t best;
    level_t lvl_s1;
    level_t lvl_s2;

    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (active[i] && (levels[i] > best)) best = levels[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_s1 <= '0;
            lvl_s2 <= '0;
        end else begin
            lvl_s1 <= best;
            lvl_s2 <= lvl_s1;
        end
    end

    assign irq_level = (lvl_s2 > core_mask) ? lvl_s2 : '0;

    AST_LVL_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (lvl_s2 != '0) |-> $past(active != '0, 2)) else $error("level without source"); // R5

endmodule

// File: rtl/irq_ack_select.sv
module irq_ack_select
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int VEC_BASE = 64,
    parameter int SPUR_VEC = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   active,
    input  level_t [NUM_SRC-1:0] levels,
    input  logic                 iack,
    input  level_t               iack_level,
    output ack_rsp_t             rsp
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic             found;
    logic [IDX_W-1:0] win_idx;

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!found && active[i] && (levels[i] == iack_level) && (iack_level != '0)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.valid <= iack;
            if (iack) begin
                rsp.vector <= found ? vector_t'(VEC_BASE + int'(win_idx))
                                    : vector_t'(SPUR_VEC);
            end
        end
    end

    AST_SPUR_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (iack && !found) |=> (rsp.vector == vector_t'(SPUR_VEC))) else $error("missing spurious"); // R7

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int VEC_BASE = 64,
    parameter int SPUR_VEC = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_n_i,
    input  logic               bus_we,
    input  logic [4:0]         bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    input  logic [2:0]         core_mask_i,
    output logic [2:0]         irq_level_o,
    input  logic               iack_i,
    input  logic [2:0]         iack_level_i,
    output logic               ack_valid_o,
    output logic [7:0]         ack_vector_o
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0]   mask_q;
    logic [NUM_SRC-1:0]   mode_q;
    level_t [NUM_SRC-1:0] lvl_q;
    logic [NUM_SRC-1:0]   pend_w;
    logic [NUM_SRC-1:0]   clr_w;
    logic [NUM_SRC-1:0]   active_w;
    reg_sel_e             sel;
    logic [3:0]           lvl_idx;
    ack_rsp_t             rsp;

    assign sel     = decode_addr(bus_addr, NUM_SRC);
    assign lvl_idx = bus_addr[3:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            mode_q <= '0;
            lvl_q  <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_MASK:  mask_q <= bus_wdata;
                SEL_MODE:  mode_q <= bus_wdata;
                SEL_LEVEL: lvl_q[lvl_idx] <= bus_wdata[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_MASK:  bus_rdata = mask_q;
            SEL_MODE:  bus_rdata = mode_q;
            SEL_PEND:  bus_rdata = pend_w;
            SEL_LEVEL: bus_rdata[LVL_W-1:0] = lvl_q[lvl_idx];
            default:   bus_rdata = '0;
        endcase
    end

    assign clr_w    = (bus_we && sel == SEL_PEND) ? bus_wdata : '0;
    assign active_w = pend_w & ~mask_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pin
        irq_pin_capture u_cap (
            .clk       (clk),
            .rst       (rst),
            .pin_n     (irq_n_i[g]),
            .edge_mode (mode_q[g]),
            .clr       (clr_w[g]),
            .pending   (pend_w[g])
        );
    end

    irq_level_resolve #(.NUM_SRC(NUM_SRC)) u_resolve (
        .clk       (clk),
        .rst       (rst),
        .active    (active_w),
        .levels    (lvl_q),
        .core_mask (core_mask_i),
        .irq_level (irq_level_o)
    );

    irq_ack_select #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE), .SPUR_VEC(SPUR_VEC)) u_ack (
        .clk        (clk),
        .rst        (rst),
        .active     (active_w),
        .levels     (lvl_q),
        .iack       (iack_i),
        .iack_level (iack_level_i),
        .rsp        (rsp)
    );

    assign ack_valid_o  = rsp.valid;
    assign ack_vector_o = rsp.vector;

    logic [NUM_SRC-1:0] mask_prev;
    logic [7:0]         ack_off;
    always_ff @(posedge clk) mask_prev <= mask_q;
    assign ack_off = ack_vector_o - 8'(VEC_BASE);

    AST_LVL_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
        (irq_level_o != '0) |-> (irq_level_o > core_mask_i)) else $error("level not above mask"); // R4

    AST_ACK_AFTER_IACK: assert property (@(posedge clk) disable iff (rst)
        ack_valid_o |-> $past(iack_i)) else $error("vector without acknowledge"); // R6

    AST_VEC_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        (ack_valid_o && ack_vector_o != 8'(SPUR_VEC)) |-> !mask_prev[ack_off[IDX_W-1:0]])
        else $error("masked source won"); // R3

endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    localparam int N    = 6;
    localparam int BASE = 64;
    localparam int SPUR = 24;

    logic         clk = 0;
    logic         rst = 1;
    logic [N-1:0] irq_n = '1;
    logic         bus_we = 0;
    logic [4:0]   bus_addr = 0;
    logic [N-1:0] bus_wdata = 0;
    logic [N-1:0] bus_rdata;
    logic [2:0]   core_mask = 0;
    logic [2:0]   irq_level;
    logic         iack = 0;
    logic [2:0]   iack_level = 0;
    logic         ack_valid;
    logic [7:0]   ack_vector;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    irq_prio_ctrl #(.NUM_SRC(N), .VEC_BASE(BASE), .SPUR_VEC(SPUR)) u_dut (
        .clk(clk), .rst(rst), .irq_n_i(irq_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_mask_i(core_mask),
        .irq_level_o(irq_level), .iack_i(iack), .iack_level_i(iack_level),
        .ack_valid_o(ack_valid), .ack_vector_o(ack_vector)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        bus_addr  = 5'(a);
        bus_wdata = N'(d);
        bus_we    = 1;
        @(negedge clk);
        bus_we    = 0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = 5'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_lvl(input int exp, input string tag);
        check(int'(irq_level) == exp, tag, int'(irq_level), exp);
    endtask

    // driver: pushes the expected vector, pulses acknowledge for one edge
    task automatic do_ack(input int lvl, input int exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        iack_level = 3'(lvl);
        iack = 1;
        @(negedge clk);
        iack = 0;
    endtask

    // monitor: pops and compares each vector as it appears
    always @(negedge clk) begin
        if (!rst && ack_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected vector", int'(ack_vector), -1);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(int'(ack_vector) == e, t, int'(ack_vector), e);
            end
        end
    end

    bit done = 0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int d;
        wait_cyc(3);
        rst = 0;
        wait_cyc(1);
        // R1 reset state
        chk_lvl(0, "R1 level after reset");
        check(ack_valid == 0, "R1 ack_valid after reset", int'(ack_valid), 0);
        rd(0, d); check(d == 'h3F, "R1 mask reset", d, 'h3F);
        rd(16, d); check(d == 0, "R1 level reg reset", d, 0);
        rd(1, d); check(d == 0, "R1 mode reset", d, 0);

        // levels: s0=3 s1=5 s2=5 s3=0 s4=7 s5=2 ; pin4 edge mode
        wr(16, 3); wr(17, 5); wr(18, 5); wr(19, 0); wr(20, 7); wr(21, 2);
        rd(17, d); check(d == 5, "R2 level readback", d, 5);
        wr(1, 'h10);

        // R3 masked source ignored
        irq_n[1] = 0;
        wait_cyc(5);
        chk_lvl(0, "R3 masked source ignored");
        do_ack(5, SPUR, "R3 masked source spurious on ack");
        wr(0, 0);
        wait_cyc(4);
        chk_lvl(5, "R5 level 5 recognized");

        // R10 tie at level 5
        irq_n[2] = 0;
        wait_cyc(4);
        do_ack(5, BASE + 1, "R10 lower index wins");
        irq_n[1] = 1;
        wait_cyc(4);
        do_ack(5, BASE + 2, "R6 remaining source vector");

        // R4 strict comparison
        core_mask = 5; #1;
        chk_lvl(0, "R4 equal mask blocks");
        core_mask = 4; #1;
        chk_lvl(5, "R4 lower mask passes");
        core_mask = 0;

        // R2 level 0 never interrupts
        irq_n[3] = 0;
        irq_n[2] = 1;
        wait_cyc(5);
        chk_lvl(0, "R2 level-0 source silent");
        rd(2, d); check(d == 'h08, "R9 pending shows level-0 pin", d, 'h08);

        // R8 edge capture
        irq_n[4] = 0; wait_cyc(1); irq_n[4] = 1;
        wait_cyc(5);
        rd(2, d); check(d == 'h18, "R8 edge flag set", d, 'h18);
        chk_lvl(7, "R8 sticky edge recognized");
        do_ack(7, BASE + 4, "R8 edge source vector");
        wr(2, 'h10);
        wait_cyc(4);
        chk_lvl(0, "R8 flag cleared by write one");
        rd(2, d); check(d == 'h08, "R8 pending after clear", d, 'h08);

        // R9 level follows pin
        irq_n[0] = 0;
        wait_cyc(4);
        chk_lvl(3, "R9 level pin low pending");
        irq_n[0] = 1;
        wait_cyc(4);
        chk_lvl(0, "R9 level pin released");
        irq_n[3] = 1;

        // R7 race: mask set inside recognition window
        irq_n[5] = 0;
        wait_cyc(5);
        chk_lvl(2, "R5 level 2 recognized");
        wr(0, 'h20);
        chk_lvl(2, "R5 window first cycle");
        do_ack(2, SPUR, "R7 mask set in window");
        chk_lvl(2, "R5 window second cycle");
        wait_cyc(1);
        chk_lvl(0, "R5 level drops after two cycles");
        wr(0, 0);
        irq_n[5] = 1;

        // R7 race: edge flag cleared inside window
        irq_n[4] = 0; wait_cyc(1); irq_n[4] = 1;
        wait_cyc(5);
        chk_lvl(7, "R8 second edge");
        wr(2, 'h10);
        do_ack(7, SPUR, "R7 request cleared in window");
        do_ack(1, SPUR, "R7 no source at level 1");
        wait_cyc(3);
        check(exp_q.size() == 0, "R6 all vectors returned", exp_q.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule